// File: doc/BRIEF.md
# TDM Quadrant Bit-Override Unit

This unit sits on the receive side of a multi-stream time-division switch. Each channel byte arrives with its stream number and its channel slot. The unit can pass the byte through untouched, or it can pin either the least significant bit or the most significant bit to a fixed level. Which of these happens depends on the stream and on the quarter of the frame that holds the channel.

Every stream owns one 16-bit configuration word. That word holds four 3-bit codes, one for each quarter of the frame. A quarter is a quadrant, and its size in channels follows the line rate set by a 2-bit mode input. Software reaches the words through a plain address/data bus. The modified byte comes out one clock after the byte goes in, and the unit accepts a new byte on every clock.

Top module: `tdm_quad_override`

## Requirements
- R1: After reset, every stream's configuration word reads back as 0x0000, and all bytes pass through unchanged.
- R2: The configuration word of stream s lives at word address 0x0120+s, for s from 0 to 15. A write stores bits 11..0. A read returns those bits, and bits 15..12 always read as zero, whatever was written to them.
- R3: A write to any address outside 0x0120..0x012F changes no configuration word. A read of such an address returns 0x0000.
- R4: A quadrant code whose bit 2 is 0 leaves the byte unchanged.
- R5: Code 100 forces bit 0 of the byte to 0. Code 101 forces bit 0 to 1. The other bits are unchanged.
- R6: Code 110 forces bit 7 of the byte to 0. Code 111 forces bit 7 to 1. The other bits are unchanged.
- R7: Quadrant q is controlled by configuration bits 3q+2..3q. Mode 00, 01, 10 and 11 select frames of 32, 64, 128 and 256 channels. The quadrant is the channel index divided by a quarter of the frame length: quadrant 0 holds the lowest quarter of channels and quadrant 3 the highest.
- R8: A channel index at or above the frame length of the current mode passes unchanged, whatever its stream's codes are.
- R9: out_valid equals in_valid delayed by one clock. While out_valid is 1, out_stream and out_byte carry the stream and the modified byte of that delayed input. Valid inputs on back-to-back clocks are all processed.
- R10: A byte presented on the same clock as a configuration write uses the old setting. Bytes on later clocks use the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration bus |
| cfg_addr | input | 16 | Word address for reads and writes |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| rate_mode | input | 2 | Line rate: 00/01/10/11 give 32/64/128/256 channels |
| in_valid | input | 1 | Input byte is valid |
| in_stream | input | 4 | Stream number of the input byte |
| in_chan | input | 8 | Channel slot of the input byte |
| in_byte | input | 8 | Input channel byte |
| out_valid | output | 1 | Output byte is valid |
| out_stream | output | 4 | Stream number of the output byte |
| out_byte | output | 8 | Modified channel byte |

## Verification
The bench drives the first and last channel of every quadrant in all four modes, and also the first channel past the end of each shorter frame. A decoder that shifts by the wrong amount, or that indexes the wrong code field, would alter a neighbouring quarter or an out-of-frame slot. It writes all ones to bits 15..12 and writes to addresses just below and just above the valid range. A design that stored the upper bits, or that aliased those addresses onto a stream, would read back the wrong value. It also issues a write on the same clock as a byte on the affected stream, which catches a design whose new setting applies one clock too early. A long random run of all codes, streams and rates, with gaps between valid bytes, catches swapped bit 0 and bit 7 forcing and a lost or extra valid cycle.

// File: rtl/tqo_pkg.sv
package tqo_pkg;
    localparam int NUM_STREAMS = 16;
    localparam int STREAM_W    = $clog2(NUM_STREAMS);
    localparam int CHAN_W      = 8;
    localparam int BYTE_W      = 8;
    localparam int CODE_W      = 3;
    localparam int NUM_QUAD    = 4;
    localparam int LIVE_W      = CODE_W * NUM_QUAD;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 16;
    localparam int RATE_W      = 2;
    localparam int NUM_RATES   = 1 << RATE_W;
    localparam int MIN_LOG2    = 5;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_LOW   = 2'd1,
        ACT_HIGH  = 2'd2
    } act_e;
endpackage

// File: rtl/tqo_regfile.sv
module tqo_regfile #(
    parameter int NUM_STREAMS = 16,
    parameter int LIVE_W      = 12,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0120
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_wr,
    input  logic [ADDR_W-1:0]                   cfg_addr,
    input  logic [DATA_W-1:0]                   cfg_wdata,
    output logic [DATA_W-1:0]                   cfg_rdata,
    output logic [NUM_STREAMS-1:0][LIVE_W-1:0]  cfg_o
);
    localparam int IDX_W = $clog2(NUM_STREAMS);

    typedef struct packed {
        logic [NUM_STREAMS-1:0][LIVE_W-1:0] cfg;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [ADDR_W-1:0] off;
    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              unused_hi;

    assign unused_hi = ^cfg_wdata[DATA_W-1:LIVE_W];

    always_comb begin
        off       = cfg_addr - BASE_ADDR;
        hit       = (cfg_addr >= BASE_ADDR) && (off < ADDR_W'(NUM_STREAMS));
        idx       = off[IDX_W-1:0];
        regs_d    = regs_q;
        if (cfg_wr && hit) begin
            regs_d.cfg[idx] = cfg_wdata[LIVE_W-1:0];
        end
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[LIVE_W-1:0] = regs_q.cfg[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_o = regs_q.cfg;
endmodule

// File: rtl/tqo_quad_decode.sv
module tqo_quad_decode #(
    parameter int CHAN_W    = 8,
    parameter int RATE_W    = 2,
    parameter int MIN_LOG2  = 5
) (
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [1:0]        quad_o,
    output logic              in_range_o
);
    localparam int NUM_RATES = 1 << RATE_W;

    logic [NUM_RATES-1:0][1:0] quad_c;
    logic [NUM_RATES-1:0]      inr_c;
    logic                      unused_chan;

    assign unused_chan = ^chan_i;

    for (genvar m = 0; m < NUM_RATES; m++) begin : g_rate
        localparam int SH = MIN_LOG2 + m;
        assign quad_c[m] = chan_i[SH-1 -: 2];
        if (SH >= CHAN_W) begin : g_full
            assign inr_c[m] = 1'b1;
        end else begin : g_part
            assign inr_c[m] = (chan_i[CHAN_W-1:SH] == '0);
        end
    end

    always_comb begin
        quad_o     = quad_c[rate_i];
        in_range_o = inr_c[rate_i];
    end
endmodule

// File: rtl/tqo_byte_mod.sv
module tqo_byte_mod
    import tqo_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CODE_W = 3
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [BYTE_W-1:0] byte_o
);
    act_e act;

    always_comb begin
        act    = ACT_PASS;
        if (code_i[2]) begin
            act = code_i[1] ? ACT_HIGH : ACT_LOW;
        end
        byte_o = byte_i;
        case (act)
            ACT_LOW:  byte_o[0]        = code_i[0];
            ACT_HIGH: byte_o[BYTE_W-1] = code_i[0];
            default:  byte_o           = byte_i;
        endcase
    end
endmodule

// File: rtl/tdm_quad_override.sv
module tdm_quad_override
    import tqo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [RATE_W-1:0]    rate_mode,
    input  logic                 in_valid,
    input  logic [STREAM_W-1:0]  in_stream,
    input  logic [CHAN_W-1:0]    in_chan,
    input  logic [BYTE_W-1:0]    in_byte,
    output logic                 out_valid,
    output logic [STREAM_W-1:0]  out_stream,
    output logic [BYTE_W-1:0]    out_byte
);
    typedef struct packed {
        logic                valid;
        logic [STREAM_W-1:0] stream;
        logic [BYTE_W-1:0]   data;
    } pipe_t;

    logic [NUM_STREAMS-1:0][LIVE_W-1:0] cfg;
    logic [LIVE_W-1:0]                  sel_cfg;
    logic [1:0]                         quad;
    logic                               in_range;
    logic [CODE_W-1:0]                  code;
    logic [BYTE_W-1:0]                  mod_byte;
    pipe_t                              pipe_d, pipe_q;

    tqo_regfile #(
        .NUM_STREAMS (NUM_STREAMS),
        .LIVE_W      (LIVE_W),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (16'h0120)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (cfg)
    );

    tqo_quad_decode #(
        .CHAN_W   (CHAN_W),
        .RATE_W   (RATE_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_dec (
        .chan_i     (in_chan),
        .rate_i     (rate_mode),
        .quad_o     (quad),
        .in_range_o (in_range)
    );

    always_comb begin
        sel_cfg = cfg[in_stream];
        code    = in_range ? sel_cfg[quad*CODE_W +: CODE_W] : '0;
    end

    tqo_byte_mod #(
        .BYTE_W (BYTE_W),
        .CODE_W (CODE_W)
    ) u_mod (
        .byte_i (in_byte),
        .code_i (code),
        .byte_o (mod_byte)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.valid = in_valid;
        if (in_valid) begin
            pipe_d.stream = in_stream;
            pipe_d.data   = mod_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.valid;
    assign out_stream = pipe_q.stream;
    assign out_byte   = pipe_q.data;
endmodule

// File: rtl/tqo_checker.sv
module tqo_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  in_stream,
    input logic [7:0]  in_byte,
    input logic        out_valid,
    input logic [3:0]  out_stream,
    input logic [7:0]  out_byte,
    input logic [15:0] cfg_rdata
);
    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    stream_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_stream == $past(in_stream)));

    // R4
    mid_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_byte[6:1] == $past(in_byte[6:1])));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15:12] == 4'h0);
endmodule

bind tdm_quad_override tqo_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_stream  (in_stream),
    .in_byte    (in_byte),
    .out_valid  (out_valid),
    .out_stream (out_stream),
    .out_byte   (out_byte),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/tdm_quad_override_test.sv
module tdm_quad_override_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [15:0] cfg_addr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic [1:0]  rate_mode;
    logic        in_valid;
    logic [3:0]  in_stream;
    logic [7:0]  in_chan;
    logic [7:0]  in_byte;
    logic        out_valid;
    logic [3:0]  out_stream;
    logic [7:0]  out_byte;

    always #5 clk = ~clk;

    tdm_quad_override uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rate_mode(rate_mode),
        .in_valid(in_valid), .in_stream(in_stream), .in_chan(in_chan),
        .in_byte(in_byte), .out_valid(out_valid), .out_stream(out_stream),
        .out_byte(out_byte)
    );

    int          errors = 0;
    int          checks = 0;
    int unsigned model [16];
    bit          have_exp = 0;
    logic        exp_valid;
    logic [3:0]  exp_stream;
    logic [7:0]  exp_byte;
    string       exp_tag;
    string       tag_override = "";

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void ref_byte(input logic [3:0] s, input logic [7:0] c,
                                     input logic [7:0] b, input logic [1:0] r,
                                     output logic [7:0] o, output string t);
        int flen;
        int q;
        int code;
        flen = 32 << r;
        o    = b;
        if (int'(c) >= flen) begin
            t = "R8";
            return;
        end
        q    = int'(c) / (flen / 4);
        code = int'((model[s] >> (3 * q)) & 7);
        if (code < 4) begin
            t = "R4";
        end else if (code < 6) begin
            o[0] = (code & 1) != 0;
            t = "R5";
        end else begin
            o[7] = (code & 1) != 0;
            t = "R6";
        end
    endfunction

    task automatic cycle(input logic v, input logic [3:0] s, input logic [7:0] c,
                         input logic [7:0] b, input logic [1:0] r, input logic wr,
                         input logic [15:0] a, input logic [15:0] wd);
        int exp_rd;
        @(negedge clk);
        if (have_exp) begin
            check("R9 valid", int'(out_valid), int'(exp_valid));
            if (exp_valid) begin
                check("R9 stream", int'(out_stream), int'(exp_stream));
                check(exp_tag, int'(out_byte), int'(exp_byte));
            end
        end
        in_valid = v; in_stream = s; in_chan = c; in_byte = b; rate_mode = r;
        cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
        #1;
        if (a >= 16'h0120 && a <= 16'h012F) begin
            exp_rd = int'(model[a - 16'h0120]);
            check("R2 read", int'(cfg_rdata), exp_rd);
        end else begin
            check("R3 read", int'(cfg_rdata), 0);
        end
        exp_valid  = v;
        exp_stream = s;
        if (v) ref_byte(s, c, b, r, exp_byte, exp_tag);
        if (tag_override != "") exp_tag = tag_override;
        have_exp = 1;
        @(posedge clk);
        if (wr && a >= 16'h0120 && a <= 16'h012F) model[a - 16'h0120] = wd & 16'h0FFF;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 0;
        rst_n = 1'b0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; rate_mode = 0;
        in_valid = 0; in_stream = 0; in_chan = 0; in_byte = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word, and a byte passes unchanged
        for (int i = 0; i < 16; i++) begin
            cfg_addr = 16'h0120 + 16'(i);
            #1;
            check("R1 reset read", int'(cfg_rdata), 0);
        end
        tag_override = "R1";
        cycle(1, 4'd7, 8'd3, 8'hA5, 2'd0, 0, 16'h0120, 0);
        tag_override = "";

        // R2: upper bits read as zero
        cycle(0, 0, 0, 0, 0, 1, 16'h0123, 16'hFFFF);
        cycle(0, 0, 0, 0, 0, 0, 16'h0123, 0);
        cycle(0, 0, 0, 0, 0, 1, 16'h0123, 16'h0000);

        // R3: out-of-range writes ignored, reads zero
        cycle(0, 0, 0, 0, 0, 1, 16'h011F, 16'h0FFF);
        cycle(0, 0, 0, 0, 0, 1, 16'h0130, 16'h0FFF);
        for (int i = 0; i < 16; i++) cycle(0, 0, 0, 0, 0, 0, 16'h0120 + 16'(i), 0);
        cycle(0, 0, 0, 0, 0, 0, 16'h0130, 0);
        tag_override = "R3";
        cycle(1, 4'd0, 8'd0, 8'hFF, 2'd0, 0, 16'h011F, 0);
        cycle(1, 4'd15, 8'd0, 8'hFF, 2'd0, 0, 16'h0130, 0);
        tag_override = "";

        // R7: quadrant boundaries in every mode; R8: first slot past the frame
        cycle(0, 0, 0, 0, 0, 1, 16'h0125, 16'(4 | (5 << 3) | (6 << 6) | (7 << 9)));
        for (int r = 0; r < 4; r++) begin
            int flen = 32 << r;
            for (int q = 0; q < 4; q++) begin
                logic [7:0] b = (q == 0 || q == 2) ? 8'hFF : 8'h00;
                tag_override = "R7";
                cycle(1, 4'd5, 8'(q * flen / 4), b, 2'(r), 0, 16'h0125, 0);
                cycle(1, 4'd5, 8'((q + 1) * flen / 4 - 1), b, 2'(r), 0, 16'h0125, 0);
            end
            if (flen < 256) begin
                tag_override = "R8";
                cycle(1, 4'd5, 8'(flen), 8'hFF, 2'(r), 0, 16'h0125, 0);
                cycle(1, 4'd5, 8'hFF, 8'h00, 2'(r), 0, 16'h0125, 0);
            end
        end
        tag_override = "";

        // R10: write on the same clock as a byte uses the old setting
        tag_override = "R10";
        cycle(1, 4'd2, 8'd0, 8'hFF, 2'd0, 1, 16'h0122, 16'h0004);
        cycle(1, 4'd2, 8'd0, 8'hFF, 2'd0, 0, 16'h0122, 0);
        cycle(1, 4'd2, 8'd1, 8'hFF, 2'd0, 1, 16'h0122, 16'h0000);
        cycle(1, 4'd2, 8'd1, 8'hFF, 2'd0, 0, 16'h0122, 0);
        tag_override = "";

        // R4 R5 R6 R9: random traffic with gaps and config changes
        for (int n = 0; n < 4000; n++) begin
            logic        v  = ($urandom % 4) != 0;
            logic        wr = ($urandom % 6) == 0;
            logic [15:0] a  = (($urandom % 10) == 0) ? 16'($urandom) : 16'h0120 + 16'($urandom % 16);
            cycle(v, 4'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), wr, a, 16'($urandom));
        end
        cycle(0, 0, 0, 0, 0, 0, 16'h0120, 0);
        cycle(0, 0, 0, 0, 0, 0, 16'h0120, 0);
        finish_run();
    end
endmodule